// File: doc/BRIEF.md
# Exception State and Trap Entry Unit

This block holds the exception bookkeeping registers of a simple 32-bit processor and decides, each cycle, whether control must move to the exception handler. It watches the decoder's opcode, the ALU overflow flag, the memory system's address-error and bus-error flags, the syscall and breakpoint flags, and five external hardware interrupt lines. When any of these calls for a trap, it asserts a redirect in the same cycle, supplies the fixed handler address, and on the closing clock edge records the exception code, the address of the offending instruction and, for address errors, the faulting data address.

Interrupt requests are latched per level as pending bits on their rising edge, whether or not they are currently masked. An interrupt is only taken while the global enable is set and at least one pending level is unmasked. Trap entry drops the global enable so the handler starts with interrupts off. A register-read port serves a move-from-coprocessor instruction. A register-write port lets software set the status word, rewrite the saved PC and clear pending bits.

Top module: `exc_state_unit`

## Requirements
- R1: After reset, registers 8, 12, 13 and 14 read zero and `trap_take` is low.
- R2: `trap_take` is high in the same cycle as any trap cause, and `trap_target` then equals 0x80000080.
- R3: On the edge that ends a trap cycle, register 14 (saved PC) takes `cur_pc - 4` when `pc_incr` is 1 and `cur_pc` when it is 0.
- R4: When several causes coincide, one is taken in this order: instruction bus error (code 6), load/fetch address error (4), store address error (5), data bus error (7), reserved instruction (10), overflow (12), syscall (8), breakpoint (9), interrupt (0). The taken code is driven on `trap_code` and stored in register 13 bits 5..2.
- R5: With `op_valid` high, any opcode other than 0x00, 0x02, 0x04, 0x0D, 0x23 and 0x2B raises a reserved-instruction trap. The six listed opcodes do not.
- R6: Register 12 keeps the global enable in bit 0 and the per-level masks in bits 14..10. Trap entry clears bit 0 and leaves every other bit unchanged.
- R7: Register 8 captures `fault_addr` on a code 4 or 5 trap and holds its value on every other trap.
- R8: Pending bits, read in register 13 bits 14..10, set on the rising edge of their line regardless of mask or enable. A bit clears when its line falls, or when software writes 0 to that bit of register 13.
- R9: An interrupt trap (code 0) occurs only when register 12 bit 0 is 1 and pending AND mask is nonzero.
- R10: Reads of any register number other than 8, 12, 13 and 14 return zero. Register 13 bits outside 5..2 and 14..10 read zero.
- R11: Software writes set all of registers 12 and 14 and only clear pending bits in register 13. Writes to register 8, and every write in a trap cycle, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode field holds a decoded instruction |
| opcode | input | 6 | Major opcode of the current instruction |
| ovf_flag | input | 1 | Signed arithmetic overflow |
| adel_flag | input | 1 | Address error on load or fetch |
| ades_flag | input | 1 | Address error on store |
| ibus_flag | input | 1 | Bus error on instruction fetch |
| dbus_flag | input | 1 | Bus error on data access |
| sys_flag | input | 1 | System call instruction |
| brk_flag | input | 1 | Breakpoint instruction |
| hw_irq | input | 5 | External interrupt request lines |
| cur_pc | input | 32 | PC associated with the current instruction |
| pc_incr | input | 1 | `cur_pc` has already been advanced by 4 |
| fault_addr | input | 32 | Memory address of the current reference |
| wr_en | input | 1 | Software register write strobe |
| wr_sel | input | 5 | Register number written |
| wr_data | input | 32 | Write data |
| rd_sel | input | 5 | Register number read |
| rd_data | output | 32 | Read data (combinational) |
| trap_take | output | 1 | Redirect to the handler this cycle |
| trap_target | output | 32 | Handler address while `trap_take` is high, else zero |
| trap_code | output | 4 | Code of the trap being taken |

## Verification
The assertions assume that the cause flags and `op_valid` are meaningful in every cycle they are high, and that `cur_pc` is at least 4 whenever `pc_incr` is set, so that the saved-PC correction does not wrap. The stimulus drives all 256 combinations of the synchronous cause flags with PCs well above 4. It walks all 64 opcodes, and sweeps every interrupt line pattern against every mask value. Inputs change only at the falling edge, and interrupt lines are dropped between patterns so each one shows a clean rising edge.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int XLEN = 32;
  localparam int NSRC = 9;

  typedef enum logic [3:0] {
    EC_INT  = 4'd0,
    EC_ADEL = 4'd4,
    EC_ADES = 4'd5,
    EC_IBE  = 4'd6,
    EC_DBE  = 4'd7,
    EC_SYS  = 4'd8,
    EC_BP   = 4'd9,
    EC_RI   = 4'd10,
    EC_OV   = 4'd12
  } exc_code_e;

  // Request vector index: lower index has higher priority.
  localparam int SRC_IBE  = 0;
  localparam int SRC_ADEL = 1;
  localparam int SRC_ADES = 2;
  localparam int SRC_DBE  = 3;
  localparam int SRC_RI   = 4;
  localparam int SRC_OV   = 5;
  localparam int SRC_SYS  = 6;
  localparam int SRC_BP   = 7;
  localparam int SRC_INT  = 8;

  localparam logic [4:0] REG_BADVA  = 5'd8;
  localparam logic [4:0] REG_STATUS = 5'd12;
  localparam logic [4:0] REG_CAUSE  = 5'd13;
  localparam logic [4:0] REG_EPC    = 5'd14;

  function automatic exc_code_e src_code(input int idx);
    case (idx)
      SRC_IBE:  return EC_IBE;
      SRC_ADEL: return EC_ADEL;
      SRC_ADES: return EC_ADES;
      SRC_DBE:  return EC_DBE;
      SRC_RI:   return EC_RI;
      SRC_OV:   return EC_OV;
      SRC_SYS:  return EC_SYS;
      SRC_BP:   return EC_BP;
      default:  return EC_INT;
    endcase
  endfunction

  // Opcodes the datapath implements.
  function automatic logic op_legal(input logic [5:0] op);
    case (op)
      6'h00, 6'h02, 6'h04, 6'h0D, 6'h23, 6'h2B: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Saved PC points at the offending instruction.
  function automatic logic [XLEN-1:0] epc_value(input logic [XLEN-1:0] pc,
                                                input logic incr);
    return incr ? (pc - XLEN'(4)) : pc;
  endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio
  import exc_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic [3:0]   code,
  output logic         any
);

  always_comb begin
    grant = '0;
    code  = 4'd0;
    any   = |req;
    // Walk from lowest to highest priority so the highest wins last.
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        code     = src_code(i);
      end
    end
  end

  always_comb begin
    a_grant_onehot_r4: assert ($onehot0(grant))
      else $error("more than one trap source granted");
  end

endmodule

// File: rtl/exc_pending.sv
module exc_pending #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq,
  input  logic         clr_en,
  input  logic [N-1:0] keep,
  output logic [N-1:0] pend
);

  logic [N-1:0] irq_d;
  logic [N-1:0] rise;
  logic [N-1:0] pend_next;

  assign rise = irq & ~irq_d;

  always_comb begin
    pend_next = (pend | rise) & irq;
    if (clr_en) pend_next = pend_next & keep;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_d <= '0;
      pend  <= '0;
    end else begin
      irq_d <= irq;
      pend  <= pend_next;
    end
  end

  // A pending bit never survives without its line having been high.
  p_pend_needs_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(irq)) == '0);

  // A rising line without a clear latches a pending bit.
  p_rise_latches_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && (rise != '0)) |=> ((pend & $past(rise)) == $past(rise)));

endmodule

// File: rtl/exc_state_unit.sv
module exc_state_unit
  import exc_pkg::*;
#(
  parameter int          NIRQ   = 5,
  parameter int          IP_LSB = 10,
  parameter int          IE_BIT = 0,
  parameter logic [31:0] VECTOR = 32'h8000_0080
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [5:0]      opcode,
  input  logic            ovf_flag,
  input  logic            adel_flag,
  input  logic            ades_flag,
  input  logic            ibus_flag,
  input  logic            dbus_flag,
  input  logic            sys_flag,
  input  logic            brk_flag,
  input  logic [NIRQ-1:0] hw_irq,
  input  logic [31:0]     cur_pc,
  input  logic            pc_incr,
  input  logic [31:0]     fault_addr,
  input  logic            wr_en,
  input  logic [4:0]      wr_sel,
  input  logic [31:0]     wr_data,
  input  logic [4:0]      rd_sel,
  output logic [31:0]     rd_data,
  output logic            trap_take,
  output logic [31:0]     trap_target,
  output logic [3:0]      trap_code
);

  localparam int CODE_LSB = 2;

  logic [31:0]     status_q;
  logic [31:0]     epc_q;
  logic [31:0]     badva_q;
  logic [3:0]      code_q;
  logic [NIRQ-1:0] pend;
  logic [NIRQ-1:0] irq_mask;
  logic            glob_ie;
  logic            ri_event;
  logic            int_req;
  logic            addr_err;
  logic            sw_cause_clr;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] grant;

  assign irq_mask = status_q[IP_LSB +: NIRQ];
  assign glob_ie  = status_q[IE_BIT];
  assign ri_event = op_valid && !op_legal(opcode);
  assign int_req  = glob_ie && ((pend & irq_mask) != '0);

  always_comb begin
    req           = '0;
    req[SRC_IBE]  = ibus_flag;
    req[SRC_ADEL] = adel_flag;
    req[SRC_ADES] = ades_flag;
    req[SRC_DBE]  = dbus_flag;
    req[SRC_RI]   = ri_event;
    req[SRC_OV]   = ovf_flag;
    req[SRC_SYS]  = sys_flag;
    req[SRC_BP]   = brk_flag;
    req[SRC_INT]  = int_req;
  end

  exc_prio #(.N(NSRC)) u_prio (
    .req   (req),
    .grant (grant),
    .code  (trap_code),
    .any   (trap_take)
  );

  assign sw_cause_clr = wr_en && (wr_sel == REG_CAUSE) && !trap_take;

  exc_pending #(.N(NIRQ)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq    (hw_irq),
    .clr_en (sw_cause_clr),
    .keep   (wr_data[IP_LSB +: NIRQ]),
    .pend   (pend)
  );

  assign addr_err    = grant[SRC_ADEL] || grant[SRC_ADES];
  assign trap_target = trap_take ? VECTOR : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      epc_q    <= '0;
      badva_q  <= '0;
      code_q   <= '0;
    end else if (trap_take) begin
      epc_q            <= epc_value(cur_pc, pc_incr);
      code_q           <= trap_code;
      status_q[IE_BIT] <= 1'b0;
      if (addr_err) badva_q <= fault_addr;
    end else if (wr_en) begin
      case (wr_sel)
        REG_STATUS: status_q <= wr_data;
        REG_EPC:    epc_q    <= wr_data;
        default:    ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      REG_BADVA:  rd_data = badva_q;
      REG_STATUS: rd_data = status_q;
      REG_EPC:    rd_data = epc_q;
      REG_CAUSE: begin
        rd_data[CODE_LSB +: 4]  = code_q;
        rd_data[IP_LSB +: NIRQ] = pend;
      end
      default:    rd_data = '0;
    endcase
  end

  // Saved PC after trap entry.
  p_epc_fix_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> (epc_q + ($past(pc_incr) ? 32'd4 : 32'd0)) == $past(cur_pc));

  // Stored code follows the driven code.
  p_code_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> code_q == $past(trap_code));

  // Global enable dropped on entry, other status bits untouched.
  p_ie_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> !status_q[IE_BIT] &&
      ((status_q | (32'd1 << IE_BIT)) == ($past(status_q) | (32'd1 << IE_BIT))));

  // Faulting address held on non-address traps.
  p_bad_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && trap_code != EC_ADEL && trap_code != EC_ADES) |=> $stable(badva_q));

  // Reserved-instruction traps need a valid opcode.
  p_ri_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && trap_code == EC_RI) |-> op_valid);

  // Interrupt traps only with the global enable set.
  p_int_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && trap_code == EC_INT) |-> glob_ie);

  // No software write lands in a trap cycle.
  p_wr_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && wr_en && wr_sel == REG_EPC) |=> epc_q != $past(wr_data) ||
      epc_q == epc_value($past(cur_pc), $past(pc_incr)));

endmodule

// File: tb/tb_exc_state_unit.sv
module tb_exc_state_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [5:0]  opcode;
  logic        ovf_flag, adel_flag, ades_flag, ibus_flag, dbus_flag;
  logic        sys_flag, brk_flag;
  logic [4:0]  hw_irq;
  logic [31:0] cur_pc;
  logic        pc_incr;
  logic [31:0] fault_addr;
  logic        wr_en;
  logic [4:0]  wr_sel;
  logic [31:0] wr_data;
  logic [4:0]  rd_sel;
  logic [31:0] rd_data;
  logic        trap_take;
  logic [31:0] trap_target;
  logic [3:0]  trap_code;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  exc_state_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .ovf_flag(ovf_flag), .adel_flag(adel_flag), .ades_flag(ades_flag),
    .ibus_flag(ibus_flag), .dbus_flag(dbus_flag), .sys_flag(sys_flag),
    .brk_flag(brk_flag), .hw_irq(hw_irq), .cur_pc(cur_pc), .pc_incr(pc_incr),
    .fault_addr(fault_addr), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .trap_take(trap_take),
    .trap_target(trap_target), .trap_code(trap_code)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic quiet();
    op_valid = 0; opcode = 0; ovf_flag = 0; adel_flag = 0; ades_flag = 0;
    ibus_flag = 0; dbus_flag = 0; sys_flag = 0; brk_flag = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0;
  endtask

  task automatic sw_write(input logic [4:0] sel, input logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  function automatic logic [3:0] exp_code(input logic [7:0] k);
    if (k[0]) return 4'd6;
    if (k[1]) return 4'd4;
    if (k[2]) return 4'd5;
    if (k[3]) return 4'd7;
    if (k[4]) return 4'd10;
    if (k[5]) return 4'd12;
    if (k[6]) return 4'd8;
    return 4'd9;
  endfunction

  function automatic logic legal_op(input logic [5:0] op);
    return op == 6'd0 || op == 6'd2 || op == 6'd4 || op == 6'd13 ||
           op == 6'd35 || op == 6'd43;
  endfunction

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp_bad;
    logic [31:0] exp_epc;
    logic [3:0]  exp_c;
    quiet();
    hw_irq = 0; cur_pc = 32'h100; pc_incr = 0; fault_addr = 0; rd_sel = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;

    // R1 reset state
    rd(5'd8, v);  chk(v, 0, "R1 badva");
    rd(5'd12, v); chk(v, 0, "R1 status");
    rd(5'd13, v); chk(v, 0, "R1 cause");
    rd(5'd14, v); chk(v, 0, "R1 epc");
    chk({31'd0, trap_take}, 0, "R1 trap_take");

    // R10 unmapped registers read zero
    for (int s = 0; s < 32; s++) begin
      if (s != 8 && s != 12 && s != 13 && s != 14) begin
        rd(5'(s), v); chk(v, 0, "R10 unmapped read");
      end
    end

    // R2 R3 R4 R7: sweep every combination of synchronous causes
    exp_bad = 0;
    exp_epc = 0;
    for (int k = 0; k < 256; k++) begin
      logic [7:0] kb;
      kb = 8'(k);
      ibus_flag = kb[0]; adel_flag = kb[1]; ades_flag = kb[2]; dbus_flag = kb[3];
      op_valid = kb[4]; opcode = 6'h3F;
      ovf_flag = kb[5]; sys_flag = kb[6]; brk_flag = kb[7];
      cur_pc = 32'h0040_1000 + 32'(k) * 4;
      pc_incr = kb[0] ^ kb[3] ^ kb[6];
      fault_addr = 32'hA000_0000 | 32'(k);
      #1;
      chk({31'd0, trap_take}, {31'd0, kb != 0}, "R2 trap_take");
      if (kb != 0) begin
        exp_c = exp_code(kb);
        chk(trap_target, 32'h8000_0080, "R2 target");
        chk({28'd0, trap_code}, {28'd0, exp_c}, "R4 trap_code");
        exp_epc = pc_incr ? cur_pc - 4 : cur_pc;
        if (exp_c == 4'd4 || exp_c == 4'd5) exp_bad = fault_addr;
      end else begin
        chk(trap_target, 0, "R2 no target");
      end
      cyc();
      quiet();
      rd(5'd13, v);
      if (kb != 0) chk({28'd0, v[5:2]}, {28'd0, exp_code(kb)}, "R4 cause code");
      rd(5'd14, v); chk(v, exp_epc, "R3 epc");
      rd(5'd8, v);  chk(v, exp_bad, "R7 badva");
    end

    // R5 opcode sweep
    for (int o = 0; o < 64; o++) begin
      op_valid = 1; opcode = 6'(o);
      cur_pc = 32'h2000 + 32'(o) * 4; pc_incr = 1;
      #1;
      chk({31'd0, trap_take}, {31'd0, !legal_op(6'(o))}, "R5 opcode trap");
      cyc();
      quiet();
      if (!legal_op(6'(o))) begin
        rd(5'd13, v); chk({28'd0, v[5:2]}, 32'd10, "R5 ri code");
        rd(5'd14, v); chk(v, 32'h2000 + 32'(o) * 4 - 4, "R3 epc ri");
      end
    end
    op_valid = 1; opcode = 6'h23;
    #1; chk({31'd0, trap_take}, 0, "R5 op_valid low path legal");
    op_valid = 0; opcode = 6'h3F;
    #1; chk({31'd0, trap_take}, 0, "R5 invalid op ignored");
    quiet();

    // R6 entry clears only the enable bit
    sw_write(5'd12, 32'h5A5A_7C01);
    rd(5'd12, v); chk(v, 32'h5A5A_7C01, "R11 status write");
    // no pending bits, so no interrupt
    chk({31'd0, trap_take}, 0, "R9 enable without pending");
    sys_flag = 1; cur_pc = 32'h3000; pc_incr = 0;
    cyc(); quiet();
    rd(5'd12, v); chk(v, 32'h5A5A_7C00, "R6 ie cleared");
    rd(5'd14, v); chk(v, 32'h3000, "R3 epc no incr");

    // R11 writes ignored during a trap cycle and to register 8
    brk_flag = 1; cur_pc = 32'h4004; pc_incr = 1;
    wr_en = 1; wr_sel = 5'd12; wr_data = 32'hFFFF_FFFF;
    cyc(); quiet();
    rd(5'd12, v); chk(v, 32'h5A5A_7C00, "R11 status write blocked in trap");
    rd(5'd14, v); chk(v, 32'h4000, "R3 epc incr");
    rd(5'd8, v); exp_bad = v;
    sw_write(5'd8, 32'h1234_5678);
    rd(5'd8, v); chk(v, exp_bad, "R11 badva write ignored");
    sw_write(5'd14, 32'hCAFE_0000);
    rd(5'd14, v); chk(v, 32'hCAFE_0000, "R11 epc write");
    sw_write(5'd13, 32'hFFFF_FFFF);
    rd(5'd13, v); chk({28'd0, v[5:2]}, 32'd9, "R11 cause code not writable");
    chk(v & ~32'h0000_7C3C, 0, "R10 cause reserved bits");

    // R8 pending latches while masked and disabled
    sw_write(5'd12, 32'h0000_5400);   // masks 10101, enable off
    hw_irq = 5'b00011;
    cyc();
    chk({31'd0, trap_take}, 0, "R9 disabled no trap");
    rd(5'd13, v); chk({27'd0, v[14:10]}, 32'b00011, "R8 pending latched masked");
    hw_irq = 5'b00001;
    cyc();
    rd(5'd13, v); chk({27'd0, v[14:10]}, 32'b00001, "R8 line drop clears");
    sw_write(5'd13, 32'h0);
    rd(5'd13, v); chk({27'd0, v[14:10]}, 0, "R8 software clear");
    cyc();
    rd(5'd13, v); chk({27'd0, v[14:10]}, 0, "R8 held line no relatch");
    hw_irq = 0;
    cyc();

    // R9 sweep of line patterns against masks
    for (int m = 0; m < 32; m++) begin
      for (int p = 1; p < 32; p++) begin
        hw_irq = 0;
        wr_en = 1; wr_sel = 5'd12; wr_data = (32'(m) << 10) | 32'd1;
        cyc();
        wr_en = 0;
        hw_irq = 5'(p);
        cyc();
        chk({31'd0, trap_take}, {31'd0, (m & p) != 0}, "R9 interrupt gate");
        if ((m & p) != 0) begin
          chk({28'd0, trap_code}, 0, "R9 int code");
          cur_pc = 32'h5000; pc_incr = 0;
          cyc();
          rd(5'd12, v); chk({31'd0, v[0]}, 0, "R6 ie off after int");
          rd(5'd13, v); chk({27'd0, v[14:10]}, 32'(p), "R8 pending all levels");
        end
      end
    end
    hw_irq = 0;
    cyc();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule